// File: doc/BRIEF.md
# Two-Register Expression Stack with Memory Backing

This block is the operand stack of a zero-address execution unit. The two uppermost elements sit in dedicated registers, which feed an external arithmetic unit directly. Every deeper element lives in a single-ported RAM. A stack pointer addresses that RAM and always names the next free word. Because both operands are already in registers when an operation is requested, no operand fetch ever comes before execution.

A requester issues one operation per cycle. The operations are push, pop, replace-top, binary operation and copy-from-depth. When an operation grows the stack while both registers are full, the lower register is spilled to the RAM in the same cycle. When an operation shrinks the stack while elements remain in the RAM, one refill read follows, and the block signals busy for that one cycle. A copy from depth two or more also takes one busy cycle, because the RAM read must complete before the copied value can be pushed. Illegal requests are flagged as underflow or overflow and leave the stack untouched.

Top module: `evstack_top`

## Requirements
- R1: After reset the block is not busy, both flags are low, the top and second outputs read zero, and the stack holds no elements. A pop issued at this point raises underflow.
- R2: Push (req_op = 1) with fewer than two valid registers moves the old top into the second register and places req_data on top. It uses no memory cycle and never asserts busy.
- R3: Push with both registers valid writes the old second element to the RAM at the stack pointer and then increments the pointer, all in the request cycle, without busy. The LIFO order of later pops shows the spilled element.
- R4: Pop (req_op = 2) with both registers valid moves the second element to the top. If the RAM holds elements, busy is high for exactly the one cycle after the request, the pointer decrements, and the second register is reloaded from the RAM top word. If the RAM is empty, the block goes to one valid register with no busy cycle.
- R5: Binary operation (req_op = 4) with two valid registers writes alu_result to the top and consumes the second element. The refill that follows is the same as for a pop.
- R6: Replace (req_op = 3) with at least one valid register overwrites only the top with req_data.
- R7: Copy (req_op = 5) pushes a copy of the element req_pick positions below the top, where 0 is the top itself and 1 is the second element. For req_pick of 2 or more, the block reads the RAM at stack pointer minus (req_pick - 1), holds busy for one cycle, and then pushes the value, spilling the second element as in R3.
- R8: Busy never lasts longer than one cycle. A request that arrives while busy is ignored: it changes no element and raises no flag.
- R9: Underflow pulses for one cycle after an operation that needs more elements than the stack holds. That covers pop or replace on an empty stack, a binary operation with fewer than two registers valid, and a copy that reaches below the bottom. The stack is left unchanged.
- R10: Overflow pulses for one cycle after a push or copy that would need a spill while the RAM is full, that is, with the pointer equal to DEPTH. The stack and the pointer are left unchanged.
- R11: Operation code 0, and any code above 5, does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 3 | Operation code (0 none, 1 push, 2 pop, 3 replace, 4 binary, 5 copy) |
| req_data | input | DW | Value for push and replace |
| req_pick | input | $clog2(DEPTH+1)+1 | Copy depth, 0 = top |
| alu_result | input | DW | Result from the external ALU for a binary operation |
| top_o | output | DW | Top element |
| nos_o | output | DW | Second element |
| busy_o | output | 1 | Refill or deep-copy memory cycle in progress |
| overflow_o | output | 1 | One-cycle overflow pulse |
| underflow_o | output | 1 | One-cycle underflow pulse |

## Verification
Several properties are checked on every cycle. Busy always ends after one cycle. A busy cycle never produces a flag. The RAM port never reads and writes at once. A spill advances the pointer by one, and a pop with RAM contents starts a refill and moves the pointer down. An overflow leaves the pointer where it was. The values that come back from the RAM are another matter. Whether refilled and deep-copied elements arrive in the correct LIFO order and from the correct address can only be shown by the bench's scripted push, copy and pop sequences, which compare the top and second outputs against hand-computed stack contents.

// File: rtl/evstack_pkg.sv
package evstack_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_REPL  = 3'd3,
        OP_BINOP = 3'd4,
        OP_PICK  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_REFILL = 2'd1,
        PH_PICK   = 2'd2
    } phase_e;
endpackage

// File: rtl/evstack_ram.sv
module evstack_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // single port: one address, registered read data
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/evstack_spctr.sv
module evstack_spctr #(
    parameter int DEPTH = 16,
    parameter int SPW   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    input  logic           dec,
    output logic [SPW-1:0] sp,
    output logic           full,
    output logic           empty
);
    logic [SPW-1:0] sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (inc)      sp_d = sp_q + 1'b1;
        else if (dec) sp_d = sp_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign sp    = sp_q;
    assign full  = (sp_q == SPW'(DEPTH));
    assign empty = (sp_q == '0);
endmodule

// File: rtl/evstack_top.sv
module evstack_top
    import evstack_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [2:0]                  req_op,
    input  logic [DW-1:0]               req_data,
    input  logic [$clog2(DEPTH+1):0]    req_pick,
    input  logic [DW-1:0]               alu_result,
    output logic [DW-1:0]               top_o,
    output logic [DW-1:0]               nos_o,
    output logic                        busy_o,
    output logic                        overflow_o,
    output logic                        underflow_o
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        phase_e        phase;
        logic [1:0]    occ;
        logic [DW-1:0] top;
        logic [DW-1:0] nos;
        logic          ovf;
        logic          unf;
    } regs_t;

    regs_t q, d;

    logic [SPW-1:0] sp;
    logic           sp_full, sp_empty, sp_inc, sp_dec;
    logic           mem_we, mem_re;
    logic [AW-1:0]  mem_addr, pick_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata, push_val;
    logic           push_go, shrink, accept;
    op_e            op;

    assign op        = op_e'(req_op);
    assign accept    = req_valid && (q.phase == PH_IDLE);
    assign pick_addr = AW'(sp) - AW'(req_pick - 1'b1);

    always_comb begin
        d         = q;
        d.ovf     = 1'b0;
        d.unf     = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = AW'(sp);
        mem_wdata = q.nos;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        push_go   = 1'b0;
        push_val  = req_data;
        shrink    = 1'b0;

        unique case (q.phase)
            PH_REFILL: begin
                d.nos   = mem_rdata;
                d.phase = PH_IDLE;
            end
            PH_PICK: begin
                mem_we  = 1'b1;
                sp_inc  = 1'b1;
                d.nos   = q.top;
                d.top   = mem_rdata;
                d.phase = PH_IDLE;
            end
            default: begin
                if (accept) begin
                    unique case (op)
                        OP_PUSH: push_go = 1'b1;
                        OP_POP: begin
                            if (q.occ == 2'd0)      d.unf = 1'b1;
                            else if (q.occ == 2'd1) d.occ = 2'd0;
                            else begin
                                d.top  = q.nos;
                                shrink = 1'b1;
                            end
                        end
                        OP_REPL: begin
                            if (q.occ == 2'd0) d.unf = 1'b1;
                            else               d.top = req_data;
                        end
                        OP_BINOP: begin
                            if (q.occ != 2'd2) d.unf = 1'b1;
                            else begin
                                d.top  = alu_result;
                                shrink = 1'b1;
                            end
                        end
                        OP_PICK: begin
                            if (req_pick == '0) begin
                                if (q.occ == 2'd0) d.unf = 1'b1;
                                else begin
                                    push_go  = 1'b1;
                                    push_val = q.top;
                                end
                            end else if (req_pick == 1) begin
                                if (q.occ != 2'd2) d.unf = 1'b1;
                                else begin
                                    push_go  = 1'b1;
                                    push_val = q.nos;
                                end
                            end else if ((q.occ != 2'd2) ||
                                         (req_pick > ({1'b0, sp} + 1'b1))) begin
                                d.unf = 1'b1;
                            end else if (sp_full) begin
                                d.ovf = 1'b1;
                            end else begin
                                mem_re   = 1'b1;
                                mem_addr = pick_addr;
                                d.phase  = PH_PICK;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase

        // consuming operation: refill the second register from memory
        if (shrink) begin
            if (sp_empty) d.occ = 2'd1;
            else begin
                sp_dec   = 1'b1;
                mem_re   = 1'b1;
                mem_addr = AW'(sp - 1'b1);
                d.phase  = PH_REFILL;
            end
        end

        // growing operation: spill the second register when both are held
        if (push_go) begin
            if (q.occ != 2'd2) begin
                d.top = push_val;
                d.nos = q.top;
                d.occ = q.occ + 2'd1;
            end else if (sp_full) begin
                d.ovf = 1'b1;
            end else begin
                mem_we = 1'b1;
                sp_inc = 1'b1;
                d.nos  = q.top;
                d.top  = push_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.occ   <= 2'd0;
            q.top   <= '0;
            q.nos   <= '0;
            q.ovf   <= 1'b0;
            q.unf   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    evstack_spctr #(.DEPTH(DEPTH), .SPW(SPW)) spctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp),
        .full  (sp_full),
        .empty (sp_empty)
    );

    evstack_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) ram_i (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign top_o       = q.top;
    assign nos_o       = q.nos;
    assign busy_o      = (q.phase != PH_IDLE);
    assign overflow_o  = q.ovf;
    assign underflow_o = q.unf;
endmodule

// File: rtl/evstack_chk.sv
module evstack_chk
    import evstack_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SPW   = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [2:0]     req_op,
    input logic           busy,
    input logic           ovf,
    input logic           unf,
    input logic [1:0]     occ,
    input logic [SPW-1:0] sp,
    input logic           mem_we,
    input logic           mem_re
);
    // R8
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R8
    busy_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!ovf && !unf));

    // R4
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    // R9
    pop_empty_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_POP && occ == 2'd0) |=> unf);

    // R3
    spill_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_PUSH && occ == 2'd2 && sp != SPW'(DEPTH))
        |=> (sp == $past(sp) + 1'b1));

    // R4
    refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_POP && occ == 2'd2 && sp != '0)
        |=> (busy && sp == $past(sp) - 1'b1));

    // R2
    small_push_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_PUSH && occ != 2'd2) |-> (!mem_we && !mem_re));

    // R10
    ovf_sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $stable(sp));
endmodule

bind evstack_top evstack_chk #(.DEPTH(DEPTH), .SPW(SPW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy_o),
    .ovf       (overflow_o),
    .unf       (underflow_o),
    .occ       (q.occ),
    .sp        (sp),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/evstack_top_tb_top.sv
module evstack_top_tb_top;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int PW    = $clog2(DEPTH + 1) + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [DW-1:0] req_data;
    logic [PW-1:0] req_pick;
    logic [DW-1:0] alu_result;
    logic [DW-1:0] top_o, nos_o;
    logic          busy_o, overflow_o, underflow_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evstack_top #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_data    (req_data),
        .req_pick    (req_pick),
        .alu_result  (alu_result),
        .top_o       (top_o),
        .nos_o       (nos_o),
        .busy_o      (busy_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    typedef struct packed {
        logic [2:0]    op;
        logic [DW-1:0] data;
        logic [PW-1:0] pick;
        logic [DW-1:0] alu;
        logic [DW-1:0] etop;
        logic [DW-1:0] enos;
        logic [1:0]    mask;   // [1] check top, [0] check second
        logic          eunf;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 16'd10, 6'd0, 16'd0,  16'd10, 16'd0,  2'b10, 1'b0}, // R2
        '{3'd1, 16'd20, 6'd0, 16'd0,  16'd20, 16'd10, 2'b11, 1'b0}, // R2
        '{3'd1, 16'd30, 6'd0, 16'd0,  16'd30, 16'd20, 2'b11, 1'b0}, // R3 spill 10
        '{3'd1, 16'd40, 6'd0, 16'd0,  16'd40, 16'd30, 2'b11, 1'b0}, // R3 spill 20
        '{3'd4, 16'd0,  6'd0, 16'd70, 16'd70, 16'd20, 2'b11, 1'b0}, // R5 refill 20
        '{3'd5, 16'd0,  6'd2, 16'd0,  16'd10, 16'd70, 2'b11, 1'b0}, // R7 deep copy
        '{3'd5, 16'd0,  6'd1, 16'd0,  16'd70, 16'd10, 2'b11, 1'b0}, // R7 copy second
        '{3'd3, 16'd55, 6'd0, 16'd0,  16'd55, 16'd10, 2'b11, 1'b0}, // R6
        '{3'd5, 16'd0,  6'd0, 16'd0,  16'd55, 16'd55, 2'b11, 1'b0}, // R7 dup
        '{3'd5, 16'd0,  6'd5, 16'd0,  16'd10, 16'd55, 2'b11, 1'b0}, // R7 bottom
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd55, 16'd55, 2'b11, 1'b0}, // R4
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd55, 16'd10, 2'b11, 1'b0}, // R4
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd10, 16'd70, 2'b11, 1'b0}, // R4
        '{3'd4, 16'd0,  6'd0, 16'd99, 16'd99, 16'd20, 2'b11, 1'b0}, // R5
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd20, 16'd10, 2'b11, 1'b0}, // R4 last refill
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd10, 16'd0,  2'b10, 1'b0}, // R4 memory empty
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd0,  16'd0,  2'b00, 1'b0}, // R4 last element
        '{3'd2, 16'd0,  6'd0, 16'd0,  16'd0,  16'd0,  2'b00, 1'b1}, // R9 pop empty
        '{3'd4, 16'd0,  6'd0, 16'd0,  16'd0,  16'd0,  2'b00, 1'b1}, // R9 binop empty
        '{3'd3, 16'd7,  6'd0, 16'd0,  16'd0,  16'd0,  2'b00, 1'b1}  // R9 replace empty
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [DW-1:0] dat,
                         input logic [PW-1:0] pk, input logic [DW-1:0] alu);
        req_valid  = 1'b1;
        req_op     = op;
        req_data   = dat;
        req_pick   = pk;
        alu_result = alu;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        req_op    = 3'd0;
    endtask

    task automatic wait_idle();
        while (busy_o) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd1:    return "R2/R3 push";
            3'd2:    return "R4 pop";
            3'd3:    return "R6 replace";
            3'd4:    return "R5 binop";
            default: return "R7 copy";
        endcase
    endfunction

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        req_valid  = 1'b0;
        req_op     = 3'd0;
        req_data   = '0;
        req_pick   = '0;
        alu_result = '0;
        do_reset();

        // R1 reset state
        chk("R1 top", 32'(top_o), 32'd0);
        chk("R1 second", 32'(nos_o), 32'd0);
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 flags", 32'({overflow_o, underflow_o}), 32'd0);

        // R11 no-op codes do nothing
        issue(3'd0, 16'hAAAA, '0, '0);
        chk("R11 nop top", 32'(top_o), 32'd0);
        issue(3'd7, 16'hBBBB, '0, '0);
        chk("R11 code7 top", 32'(top_o), 32'd0);
        chk("R11 code7 flags", 32'({overflow_o, underflow_o}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].data, VECS[i].pick, VECS[i].alu);
            chk("R9 underflow flag", 32'(underflow_o), 32'(VECS[i].eunf));
            wait_idle();
            if (VECS[i].mask[1]) chk(op_tag(VECS[i].op), 32'(top_o), 32'(VECS[i].etop));
            if (VECS[i].mask[0]) chk(op_tag(VECS[i].op), 32'(nos_o), 32'(VECS[i].enos));
        end

        // R1 pop right after reset underflows
        do_reset();
        issue(3'd2, '0, '0, '0);
        chk("R1 pop after reset", 32'(underflow_o), 32'd1);

        // R4 / R8: busy exactly one cycle, request during busy ignored
        issue(3'd1, 16'd1, '0, '0);
        issue(3'd1, 16'd2, '0, '0);
        issue(3'd1, 16'd3, '0, '0);
        issue(3'd2, '0, '0, '0);
        chk("R4 busy after pop", 32'(busy_o), 32'd1);
        chk("R4 top after pop", 32'(top_o), 32'd2);
        issue(3'd1, 16'd77, '0, '0);
        chk("R8 busy cleared", 32'(busy_o), 32'd0);
        chk("R8 ignored push flags", 32'({overflow_o, underflow_o}), 32'd0);
        chk("R8 ignored push top", 32'(top_o), 32'd2);
        chk("R4 refilled second", 32'(nos_o), 32'd1);

        // R10: fill the memory, then overflow
        for (int k = 0; k < DEPTH; k++) issue(3'd1, 16'(100 + k), '0, '0);
        chk("R3 full top", 32'(top_o), 32'd115);
        chk("R3 full second", 32'(nos_o), 32'd114);
        issue(3'd1, 16'd200, '0, '0);
        chk("R10 push overflow", 32'(overflow_o), 32'd1);
        chk("R10 top kept", 32'(top_o), 32'd115);
        issue(3'd5, '0, 6'd0, '0);
        chk("R10 dup overflow", 32'(overflow_o), 32'd1);
        issue(3'd5, '0, 6'd3, '0);
        chk("R10 deep copy overflow", 32'(overflow_o), 32'd1);
        chk("R10 second kept", 32'(nos_o), 32'd114);
        chk("R10 no busy", 32'(busy_o), 32'd0);

        // R9 / R7: copy depth bounds with 15 words in memory
        issue(3'd2, '0, '0, '0);
        wait_idle();
        chk("R4 refill from full", 32'(nos_o), 32'd113);
        issue(3'd5, '0, 6'd17, '0);
        chk("R9 copy too deep", 32'(underflow_o), 32'd1);
        chk("R9 top kept", 32'(top_o), 32'd114);
        issue(3'd5, '0, 6'd16, '0);
        chk("R7 copy busy", 32'(busy_o), 32'd1);
        wait_idle();
        chk("R7 copy bottom", 32'(top_o), 32'd1);
        chk("R7 copy second", 32'(nos_o), 32'd114);

        // R9 / R6 with one register valid
        do_reset();
        issue(3'd1, 16'd5, '0, '0);
        issue(3'd4, '0, '0, 16'd9);
        chk("R9 binop one element", 32'(underflow_o), 32'd1);
        chk("R9 binop top kept", 32'(top_o), 32'd5);
        issue(3'd5, '0, 6'd1, '0);
        chk("R9 copy second missing", 32'(underflow_o), 32'd1);
        issue(3'd3, 16'd9, '0, '0);
        chk("R6 replace one element", 32'(top_o), 32'd9);
        chk("R6 no flag", 32'({overflow_o, underflow_o}), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule